// File: doc/BRIEF.md
# Accumulator Adder Datapath with Operand Register

This block is the arithmetic half of a small accumulator machine. It holds an accumulator register fed by a ripple-carry adder and a second operand register. The adder has no function decode of its own. It only adds. Each of its three inputs (the A operand, the B operand and the carry-in) passes through its own selector, and the accumulator takes the adder's sum on every clock edge.

Clear, increment, decrement, add, subtract and load all come from a choice of adder inputs together with an operand that has been prepared in the operand register. On earlier cycles the sequencer sets that register to all ones or to its own bitwise complement. The register can also take the memory read bus or keep its value. Logic operations are not part of the adder.

A sequencer outside this block drives the selectors and the operand-register mode on each cycle. The memory read bus feeds the operand register. The accumulator value and a zero flag go back to the sequencer, which uses them for conditional branches and stores.

Top module: `accum_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and the operand register both clear to 0. After reset, `acc_out` is 0 and a load operation (R8) returns 0.
- R2: On every rising edge with `rst` low, the accumulator takes (A + B + cin) mod 2^DATA_W. A is the accumulator when `a_sel`=1 and 0 when `a_sel`=0. B is the operand register when `b_sel`=1 and 0 when `b_sel`=0. cin is the value of `cin_sel`. The adder sees the operand register's value from before that same edge.
- R3: Clear (`a_sel`=0, `b_sel`=0, `cin_sel`=0) makes the accumulator 0 on the next edge.
- R4: Increment (`a_sel`=1, `b_sel`=0, `cin_sel`=1) adds one to the accumulator, and the maximum value wraps to 0.
- R5: Decrement (`a_sel`=1, `b_sel`=1, `cin_sel`=0, with the operand register all ones) subtracts one, and 0 wraps to the maximum value.
- R6: `b_mode` selects the operand register's update on each edge: 2'b00 keeps its value, 2'b01 sets it to all ones, 2'b10 loads `mem_rd`, and 2'b11 loads its own bitwise complement.
- R7: Subtract (`a_sel`=1, `b_sel`=1, `cin_sel`=1, with the operand register holding the complement of the subtrahend) gives the accumulator minus the subtrahend, mod 2^DATA_W.
- R8: Load (`a_sel`=0, `b_sel`=1, `cin_sel`=0) copies the operand register into the accumulator.
- R9: `acc_zero` is high exactly when `acc_out` is 0, with no extra cycle of delay.
- R10: Hold (`a_sel`=1, `b_sel`=0, `cin_sel`=0) leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | A operand: 1 = accumulator, 0 = zero |
| b_sel | input | 1 | B operand: 1 = operand register, 0 = zero |
| cin_sel | input | 1 | Adder carry-in value |
| b_mode | input | 2 | Operand register update: 00 keep, 01 all ones, 10 memory, 11 complement |
| mem_rd | input | DATA_W | Memory read data for the operand register |
| acc_out | output | DATA_W | Accumulator register value |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the wrap points (255 to 0 on increment, 0 to 255 on decrement) and every sign case of subtraction can be reached within a few directed cycles. A random stretch then drives all selector and mode combinations, including cases where the operand register changes on the same edge that the adder reads it, so that the old-value rule of R2 is exercised.

// File: rtl/accum_dp_pkg.sv
package accum_dp_pkg;
  typedef enum logic [1:0] {
    BM_KEEP = 2'b00,
    BM_ONES = 2'b01,
    BM_MEM  = 2'b10,
    BM_INV  = 2'b11
  } bmode_e;
endpackage

// File: rtl/operand_reg.sv
module operand_reg
  import accum_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bmode_e            mode,
  input  logic [DATA_W-1:0] mem_rd,
  output logic [DATA_W-1:0] opnd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q <= '0;
    end else begin
      unique case (mode)
        BM_KEEP: opnd_q <= opnd_q;
        BM_ONES: opnd_q <= '1;
        BM_MEM:  opnd_q <= mem_rd;
        BM_INV:  opnd_q <= ~opnd_q;
        default: opnd_q <= opnd_q;
      endcase
    end
  end

  // R6 mode checks
  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == BM_KEEP) |=> $stable(opnd_q));
  p_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == BM_ONES) |=> (&opnd_q));
  p_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == BM_MEM) |=> (opnd_q == $past(mem_rd)));
  p_inv_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == BM_INV) |=> (opnd_q == ~$past(opnd_q)));
endmodule

// File: rtl/operand_steer.sv
module operand_steer #(
  parameter int DATA_W = 8
) (
  input  logic              a_sel,
  input  logic              b_sel,
  input  logic              cin_sel,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] add_a,
  output logic [DATA_W-1:0] add_b,
  output logic              add_ci
);
  always_comb begin
    add_a  = a_sel ? acc  : '0;
    add_b  = b_sel ? opnd : '0;
    add_ci = cin_sel;
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a ^ b));
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ci,
  output logic [DATA_W-1:0] sum
);
  localparam int CHAIN = DATA_W;
  logic [CHAIN-1:0] carry;

  assign carry[0] = ci;

  for (genvar i = 0; i < CHAIN; i++) begin : g_bit
    if (i < CHAIN - 1) begin : g_full
      fa_cell u_fa (
        .a (a[i]),
        .b (b[i]),
        .ci(carry[i]),
        .s (sum[i]),
        .co(carry[i+1])
      );
    end else begin : g_top
      // the final carry leaves the word, so the top bit needs only the sum
      assign sum[i] = a[i] ^ b[i] ^ carry[i];
    end
  end
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel,
  input  logic              b_sel,
  input  logic              cin_sel,
  input  logic [1:0]        b_mode,
  input  logic [DATA_W-1:0] mem_rd,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_zero
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_ci;

  operand_reg #(.DATA_W(DATA_W)) u_opnd (
    .clk   (clk),
    .rst   (rst),
    .mode  (bmode_e'(b_mode)),
    .mem_rd(mem_rd),
    .opnd_q(opnd_q)
  );

  operand_steer #(.DATA_W(DATA_W)) u_steer (
    .a_sel  (a_sel),
    .b_sel  (b_sel),
    .cin_sel(cin_sel),
    .acc    (acc_q),
    .opnd   (opnd_q),
    .add_a  (add_a),
    .add_b  (add_b),
    .add_ci (add_ci)
  );

  ripple_adder #(.DATA_W(DATA_W)) u_add (
    .a  (add_a),
    .b  (add_b),
    .ci (add_ci),
    .sum(add_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= add_sum;
  end

  assign acc_out  = acc_q;
  assign acc_zero = (acc_q == '0);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!a_sel && !b_sel && !cin_sel) |=> (acc_out == '0));
  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (a_sel && !b_sel && cin_sel) |=> (acc_out == DATA_W'($past(acc_out) + 1'b1)));
  p_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (a_sel && b_sel && !cin_sel && (&opnd_q)) |=> (acc_out == DATA_W'($past(acc_out) - 1'b1)));
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    (!a_sel && b_sel && !cin_sel) |=> (acc_out == $past(opnd_q)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (a_sel && !b_sel && !cin_sel) |=> $stable(acc_out));
endmodule

// File: tb/accum_datapath_tb.sv
module accum_datapath_tb;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a_sel = 1'b0, b_sel = 1'b0, cin_sel = 1'b0;
  logic [1:0]   b_mode = 2'b00;
  logic [W-1:0] mem_rd = '0;
  logic [W-1:0] acc_out;
  logic         acc_zero;

  int checks = 0;
  int fails  = 0;
  int ref_acc = 0;
  int ref_b   = 0;

  always #10 clk = ~clk;

  accum_datapath #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel), .cin_sel(cin_sel),
    .b_mode(b_mode), .mem_rd(mem_rd), .acc_out(acc_out), .acc_zero(acc_zero)
  );

  task automatic check(input string tag);
    checks++;
    if (int'(acc_out) != ref_acc || acc_zero != (ref_acc == 0)) begin
      fails++;
      $display("FAIL %s: acc=%0d zero=%0b expected acc=%0d zero=%0b",
               tag, acc_out, acc_zero, ref_acc, (ref_acc == 0));
    end
  endtask

  // drive at a falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic step(input bit a, input bit b, input bit c, input bit [1:0] m,
                      input int mem, input string tag);
    int nb;
    a_sel = a; b_sel = b; cin_sel = c; b_mode = m; mem_rd = W'(mem);
    @(posedge clk);
    ref_acc = ((a ? ref_acc : 0) + (b ? ref_b : 0) + (c ? 1 : 0)) & MASK;
    case (m)
      2'b00: nb = ref_b;
      2'b01: nb = MASK;
      2'b10: nb = mem & MASK;
      default: nb = (~ref_b) & MASK;
    endcase
    ref_b = nb;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: acc=%0d expected run to finish", acc_out);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset acc");
    step(0, 1, 0, 2'b00, 0,    "R1 reset operand via load");
    step(1, 0, 0, 2'b10, 8'h5A, "R6 mem mode with R10 hold");
    step(0, 1, 0, 2'b00, 0,    "R8 load");
    step(1, 0, 0, 2'b00, 8'h33, "R10 hold");
    step(1, 0, 1, 2'b00, 0,    "R4 increment");
    step(1, 0, 1, 2'b00, 0,    "R4 increment again");
    step(1, 0, 0, 2'b10, 8'hFF, "R6 mem max");
    step(0, 1, 0, 2'b00, 0,    "R8 load max");
    step(1, 0, 1, 2'b00, 0,    "R4 wrap to zero and R9 flag");
    step(1, 0, 0, 2'b01, 0,    "R6 ones mode");
    step(1, 1, 0, 2'b00, 0,    "R5 decrement wrap");
    step(1, 1, 0, 2'b00, 0,    "R5 decrement");
    step(1, 0, 0, 2'b10, 8'h10, "R6 mem");
    step(1, 1, 0, 2'b00, 0,    "R2 add");
    step(1, 0, 0, 2'b10, 8'h20, "R6 mem subtrahend");
    step(1, 0, 0, 2'b11, 0,    "R6 complement");
    step(1, 1, 1, 2'b00, 0,    "R7 subtract negative result");
    step(1, 0, 0, 2'b10, 8'h0E, "R6 mem small");
    step(1, 0, 0, 2'b11, 0,    "R6 complement again");
    step(1, 1, 1, 2'b11, 0,    "R7 subtract with operand changing same edge");
    step(0, 1, 0, 2'b11, 0,    "R6 double complement restores via R8");
    step(0, 0, 0, 2'b00, 0,    "R3 clear");
    step(0, 0, 0, 2'b00, 0,    "R9 zero after clear");
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s;
      logic [1:0] m;
      s = 3'($urandom);
      m = 2'($urandom);
      step(s[2], s[1], s[0], m, int'($urandom) & MASK, "R2 random");
    end
    rst = 1'b1;
    @(posedge clk);
    ref_acc = 0; ref_b = 0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run");
    step(0, 1, 0, 2'b00, 0, "R1 operand cleared mid-run");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule